// File: doc/BRIEF.md
# Sequential Single-MAC FIR Filter Engine

This block filters a stream of 16-bit two's complement samples with a finite impulse response of configurable length. One multiplier and one accumulator do all the work. They step through one tap per clock. The block suits sample rates far below the clock rate, such as an audio codec that delivers one word per sample period. Each sample arrives with a one-cycle strobe. The engine stores it in a circular history buffer in place of the oldest entry, then runs a full multiply-accumulate pass over that history against a coefficient table. It returns one filtered word with a one-cycle valid pulse.

Samples and coefficients are Q15 fractions. Each product is realigned by one bit and summed in a wide accumulator with guard bits. The sum is clamped to the Q31 range. The upper 16 bits of the clamped sum form the result, and its two low bits are cleared so that the word suits a 14-bit converter. Coefficients come from a parameter at reset. A small write port can replace them while the engine is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: Synchronous active-high reset clears every stored sample to zero, reloads the coefficient table from the COEF_INIT parameter (entry k in bits [16k+15:16k]) and drives out_valid and out_data to zero. The first outputs after reset therefore see an all-zero sample history.
- R2: Suppose in_valid is high at a rising edge n while the engine is idle. Then out_valid is high for exactly one cycle, the cycle after edge n+TAPS+2, and the engine is idle again from that edge on.
- R3: The result is y = sum over k=0..TAPS-1 of c[k]*h[k], where h[0] is the oldest stored sample and h[TAPS-1] is the sample just received. The first coefficient is always paired with the oldest sample.
- R4: Each accepted sample overwrites the oldest stored one. A sample therefore stops contributing after TAPS further samples have been accepted.
- R5: Each signed 16x16 product is doubled before it is accumulated. Before clamping, out_data equals floor(2*y / 65536), with the two low bits then cleared.
- R6: Bits [1:0] of out_data are always zero.
- R7: If 2*y exceeds 2^31-1, out_data is 16'h7FFC. If 2*y is below -2^31, out_data is 16'h8000.
- R8: The engine ignores in_valid while a computation is in progress. No extra output appears, and the ignored word never enters the history.
- R9: When coef_we is high, the engine is idle and in_valid is low, coef_data is written to coefficient entry coef_addr and is used by later computations.
- R10: The engine ignores a coefficient write while a computation is in progress. The table keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_data | input | DW | New sample, Q15 two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | AW | Coefficient entry to write |
| coef_data | input | DW | Coefficient value, Q15 |
| out_valid | output | 1 | One-cycle pulse marking a filtered result |
| out_data | output | DW | Filtered result, two low bits cleared |

## Verification
The checker assumes that reset is applied before the first strobe. It also assumes that a strobe is one cycle wide whenever the engine is idle, because a held in_valid would start a new computation as soon as the previous one ends. The stimulus changes inputs on falling edges and holds every strobe and coefficient write to a single cycle. It sends a new sample only after the previous result has appeared. The only exceptions are deliberate: a strobe or coefficient write is placed inside a running computation to show that it is rejected. TAPS is assumed to be at least 2 and the accumulator wider than 32 bits. The stimulus uses the defaults.

// File: rtl/fir_pkg.sv
package fir_pkg;

  // Per-tap control carried alongside the operands through the pipeline.
  typedef struct packed {
    logic vld;    // a tap product is in flight in this stage
    logic first;  // first tap of a pass: load, do not add
    logic last;   // last tap of a pass: result complete after this add
  } tap_tag_t;

endpackage

// File: rtl/fir_tap_mem.sv
module fir_tap_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [DEPTH*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Reset reloads every entry from INIT; one write and one registered read per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= INIT[i*DW +: DW];
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int AW   = $clog2(TAPS),
  parameter int CW   = $clog2(TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          coef_we,
  input  logic          fin,
  output logic          busy,
  output logic          samp_we,
  output logic [AW-1:0] samp_waddr,
  output logic [AW-1:0] samp_raddr,
  output logic [AW-1:0] coef_raddr,
  output logic          coef_wr_ok,
  output tap_tag_t      tag
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;    // next tap index to issue
  logic [AW-1:0] dptr_q;   // next data address to read
  logic [AW-1:0] wr_q;     // slot holding the oldest sample
  logic          accept;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(TAPS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy       = busy_q;
  assign accept     = in_valid & ~busy_q;
  assign samp_we    = accept;
  assign samp_waddr = wr_q;
  assign coef_wr_ok = coef_we & ~busy_q & ~in_valid;

  // Tap 0 is issued in the strobe cycle itself: it reads the slot just past
  // the one being overwritten, which is the oldest surviving sample.
  always_comb begin
    tag        = '0;
    samp_raddr = dptr_q;
    coef_raddr = cnt_q[AW-1:0];
    if (accept) begin
      tag.vld    = 1'b1;
      tag.first  = 1'b1;
      samp_raddr = nxt(wr_q);
      coef_raddr = '0;
    end else if (busy_q && (cnt_q < CW'(TAPS))) begin
      tag.vld  = 1'b1;
      tag.last = (cnt_q == CW'(TAPS - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      dptr_q <= '0;
      wr_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
      dptr_q <= nxt(nxt(wr_q));
      wr_q   <= nxt(wr_q);
    end else begin
      if (tag.vld) begin
        cnt_q  <= cnt_q + 1'b1;
        dptr_q <= nxt(dptr_q);
      end
      if (fin) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fir_mac_dp.sv
module fir_mac_dp
  import fir_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ACCW     = 40,
  parameter int PAD_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  tap_tag_t      tag,
  input  logic [DW-1:0] coef_rd,
  input  logic [DW-1:0] samp_rd,
  output logic          fin,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int PW = 2 * DW;
  localparam logic signed [ACCW-1:0] MAXV =
    {{(ACCW - PW + 1){1'b0}}, {(PW - 1){1'b1}}};
  localparam logic signed [ACCW-1:0] MINV =
    {{(ACCW - PW + 1){1'b1}}, {(PW - 1){1'b0}}};

  tap_tag_t               tag1_q, tag2_q;
  logic signed [PW-1:0]   prod_q;
  logic signed [ACCW-1:0] prod_ext;
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] sat;
  logic                   fin_q;

  // Tag 1 lines up with the memories' registered read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag1_q <= '0;
      tag2_q <= '0;
      prod_q <= '0;
    end else begin
      tag1_q <= tag;
      tag2_q <= tag1_q;
      prod_q <= $signed(coef_rd) * $signed(samp_rd);
    end
  end

  // Sign-extend and drop the redundant sign bit (Q30 -> Q31).
  assign prod_ext = {{(ACCW - PW - 1){prod_q[PW-1]}}, prod_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fin_q <= 1'b0;
    end else begin
      if (tag2_q.vld) acc_q <= tag2_q.first ? prod_ext : acc_q + prod_ext;
      fin_q <= tag2_q.vld & tag2_q.last;
    end
  end

  always_comb begin
    if (acc_q > MAXV)      sat = MAXV;
    else if (acc_q < MINV) sat = MINV;
    else                   sat = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin_q;
      if (fin_q) out_data <= {sat[PW-1 -: DW-PAD_BITS], {PAD_BITS{1'b0}}};
    end
  end

  assign fin = fin_q;

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_pkg::*;
#(
  parameter int TAPS     = 8,
  parameter int DW       = 16,
  parameter int ACCW     = 40,
  parameter int PAD_BITS = 2,
  parameter logic [TAPS*DW-1:0] COEF_INIT = '0,
  localparam int AW = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [DW-1:0] coef_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int CW = $clog2(TAPS + 1);

  logic          busy;
  logic          samp_we;
  logic [AW-1:0] samp_waddr, samp_raddr, coef_raddr;
  logic          coef_wr_ok;
  logic          fin;
  tap_tag_t      tag;
  logic [DW-1:0] coef_rd, samp_rd;

  fir_seq #(.TAPS(TAPS), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .coef_we(coef_we), .fin(fin),
    .busy(busy), .samp_we(samp_we), .samp_waddr(samp_waddr),
    .samp_raddr(samp_raddr), .coef_raddr(coef_raddr),
    .coef_wr_ok(coef_wr_ok), .tag(tag)
  );

  fir_tap_mem #(.DEPTH(TAPS), .DW(DW), .AW(AW), .INIT('0)) u_hist (
    .clk(clk), .rst(rst), .we(samp_we), .waddr(samp_waddr), .wdata(in_data),
    .raddr(samp_raddr), .rdata(samp_rd)
  );

  fir_tap_mem #(.DEPTH(TAPS), .DW(DW), .AW(AW), .INIT(COEF_INIT)) u_coef (
    .clk(clk), .rst(rst), .we(coef_wr_ok), .waddr(coef_addr), .wdata(coef_data),
    .raddr(coef_raddr), .rdata(coef_rd)
  );

  fir_mac_dp #(.DW(DW), .ACCW(ACCW), .PAD_BITS(PAD_BITS)) u_dp (
    .clk(clk), .rst(rst), .tag(tag), .coef_rd(coef_rd), .samp_rd(samp_rd),
    .fin(fin), .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int TAPS = 8,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          busy,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  localparam logic [15:0] LAT = 16'(TAPS + 3);

  // Edges since the last accepted strobe (1 at the accepting edge), held at max.
  logic [15:0] since;
  always_ff @(posedge clk) begin
    if (rst)                                   since <= '0;
    else if (in_valid && !busy)                since <= 16'd1;
    else if (since != 0 && since != 16'hFFFF)  since <= since + 16'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since == LAT));

  // R2
  idle_at_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  // R6
  low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[1:0] == 2'b00));

  // R8
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);

endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/fir_mac_engine_bench.sv
module fir_mac_engine_bench;

  localparam int TAPS = 8;
  localparam int DW   = 16;
  localparam int AW   = $clog2(TAPS);
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [DW-1:0] coef_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  fir_mac_engine u_fir_mac_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  logic signed [DW-1:0] hist [TAPS];  // index 0 oldest
  logic signed [DW-1:0] cf   [TAPS];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model();
    logic signed [63:0] s = 0;
    for (int k = 0; k < TAPS; k++) s += 2 * longint'(cf[k]) * longint'(hist[k]);
    if (s > SMAX) s = SMAX;
    else if (s < SMIN) s = SMIN;
    s = s >>> 16;
    return {s[15:2], 2'b00};
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < TAPS; k++) begin hist[k] = '0; cf[k] = '0; end
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(out_data == '0, "R1 out_data after reset", 32'(out_data), 0);
  endtask

  task automatic wr_coef(input int a, input logic [DW-1:0] v);
    coef_we = 1'b1; coef_addr = AW'(a); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    cf[a] = v;
  endtask

  // inject: 0 none, 1 strobe during the pass, 2 coefficient write during the pass
  task automatic push(input logic [DW-1:0] x, input string req, input int inject);
    logic [DW-1:0] exp;
    for (int k = 0; k < TAPS - 1; k++) hist[k] = hist[k+1];
    hist[TAPS-1] = x;
    exp = model();
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 1; j <= TAPS + 4; j++) begin
      if (j > 1) @(negedge clk);
      chk(out_valid == (j == TAPS + 3), "R2 out_valid timing", 32'(out_valid),
          32'(j == TAPS + 3));
      if (j == TAPS + 3) begin
        chk(out_data == exp, req, 32'(out_data), 32'(exp));
        chk(out_data[1:0] == 2'b00, "R6 low bits", 32'(out_data[1:0]), 0);
      end
      if (j == 3 && inject == 1) begin in_valid = 1'b1; in_data = ~x; end
      if (j == 4 && inject == 1) in_valid = 1'b0;
      if (j == 3 && inject == 2) begin
        coef_we = 1'b1; coef_addr = '0; coef_data = 16'h7FFF;
      end
      if (j == 4 && inject == 2) coef_we = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    push(16'h4000, "R1 zero coefficients after reset", 0);
  endtask

  task automatic t_impulse();
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'((k + 1) * 16'h0800));
    push(16'h4000, "R9 written coefficients used", 0);
    for (int k = 1; k < TAPS; k++) push(16'h0000, "R3 tap order oldest first", 0);
    push(16'h0000, "R4 oldest sample overwritten", 0);
  endtask

  task automatic t_scaling();
    do_reset();
    wr_coef(TAPS - 1, 16'h4000);
    push(16'h4000, "R5 half times half", 0);
    push(16'hC000, "R5 negative product", 0);
    wr_coef(TAPS - 1, 16'h0001);
    push(16'h0004, "R5 positive truncation", 0);
    push(16'hFFFC, "R5 negative floor", 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h7FFF);
    for (int k = 0; k < 3; k++) push(16'h7FFC, "R7 positive clamp", 0);
    for (int k = 0; k < TAPS; k++) push(16'h8000, "R7 negative clamp", 0);
    do_reset();
    wr_coef(TAPS - 1, 16'h8000);
    push(16'h8000, "R7 full-scale square clamps", 0);
  endtask

  task automatic t_busy();
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h1000 + 16'(k * 16'h0100));
    for (int k = 0; k < TAPS; k++) push(16'(16'h0400 + k * 16'h0404) & 16'hFFFC, "R3 mixed history", 0);
    push(16'h2000, "R8 strobe during pass", 1);
    push(16'hE000, "R8 ignored word absent", 0);
    push(16'h1234 & 16'hFFFC, "R10 write during pass", 2);
    push(16'h0F00, "R10 coefficient kept", 0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h2000);
    for (int k = 0; k < 4; k++) push(16'h7000, "R3 warm history", 0);
    do_reset();
    for (int k = 0; k < TAPS; k++) wr_coef(k, 16'h2000);
    push(16'h4000, "R1 history cleared by reset", 0);
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset_state();
    t_impulse();
    t_scaling();
    t_saturate();
    t_busy();
    t_reset_clears();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule